// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Detection

This block turns an asynchronous serial line into parallel characters. The line idles high. A character is one low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit (even or odd) and exactly one stop bit. The line is sampled on a baud tick enable that runs at sixteen times the bit rate. The tick comes from a divider outside this block. The line passes through a two-flop synchronizer before any logic uses it.

The character length and the parity mode are fixed by parameters. A receive queue outside the block takes each stored character through a push strobe, and tells the block through a full flag when it has no room. Each completed character produces one outcome. The outcome is a push, one or more error pulses, or both. The three error kinds treat storage differently:

- A parity mismatch is reported, and the character is still stored.
- A bad stop bit or a full queue causes the character to be dropped.

Top module: `rxe_uart_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, push_valid, err_parity, err_frame and err_overrun are all 0.
- R2: A frame with a good stop bit, correct parity and fifo_full low produces exactly one push_valid pulse. push_data then holds the DATA_BITS data bits, with the first bit received in bit 0. DATA_BITS may be 5, 6, 7 or 8.
- R3: The PARITY parameter selects the mode: PAR_NONE=0, PAR_EVEN=1, PAR_ODD=2. In even mode the data bits and the parity bit together carry an even number of ones. In odd mode they carry an odd number. On a mismatch err_parity pulses and the character is still pushed, unless R5 or R6 drops it.
- R4: With PAR_NONE no parity bit is expected, so the stop bit directly follows the last data bit. In this mode err_parity never asserts.
- R5: A stop bit sampled as 0 pulses err_frame, and the character is not pushed. If that character also has a parity mismatch, err_parity pulses in the same cycle as err_frame.
- R6: If fifo_full is high when a character with a good stop bit completes, err_overrun pulses and the character is not pushed. A character with a bad stop bit never raises err_overrun.
- R7: The start bit is confirmed half a bit time after the falling edge. A low pulse that is high again by then is ignored: no push and no error.
- R8: Every output pulse lasts one cycle, and each frame gives at most one outcome. A new start bit that directly follows a stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| fifo_full | input | 1 | Receive queue has no room |
| push_valid | output | 1 | One-cycle strobe that stores push_data |
| push_data | output | DATA_BITS | Received character |
| err_parity | output | 1 | One-cycle parity mismatch pulse |
| err_frame | output | 1 | One-cycle bad stop bit pulse |
| err_overrun | output | 1 | One-cycle pulse for a character dropped on full |

## Verification
The hardest case to bring about is a stop bit held low for a whole bit time. The receiver goes back to idle at the middle of that stop bit while the line is still low, so it starts a false start bit. The bench holds the bad stop bit for the full bit time and then releases the line. It then checks that the false start is rejected at its midpoint and produces no second outcome. Overrun needs fifo_full to be high at the exact cycle a frame completes, so the bench raises the flag before the frame begins and clears it only after the frame's outcome has been drained. It also runs the overrun case together with a bad stop bit to check which error wins.

// File: rtl/rxe_pkg.sv
// Shared types for the serial receiver: parity mode and frame state.
package rxe_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam int OSR = 16;
endpackage

// File: rtl/rxe_sync.sv
// Multi-flop synchronizer for an asynchronous input.
// Assumes the input idles high, so the flops reset to 1.
module rxe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the async input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxe_framer.sv
// Frame state machine. It confirms the start bit at mid-bit, then
// samples the data bits (first bit received lands in bit 0), the
// optional parity bit and the stop bit, each at mid-bit.
// Assumes rx is already synchronized and tick is a one-cycle enable
// at OSR times the bit rate. done pulses one cycle after the stop
// bit sample, with data, par_bit and stop_bit valid in that cycle.
module rxe_framer #(
    parameter int DATA_BITS = 8,
    parameter bit PAR_EN    = 1'b1,
    parameter int OSR       = rxe_pkg::OSR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 par_bit,
    output logic                 stop_bit
);
    import rxe_pkg::*;

    localparam int CW   = $clog2(OSR);
    localparam int IW   = $clog2(DATA_BITS);
    localparam int HALF = OSR / 2;

    rx_state_e           state;
    logic [CW-1:0]       os_cnt;
    logic [IW-1:0]       bit_idx;
    logic                at_bit_mid;

    assign at_bit_mid = (os_cnt == CW'(OSR - 1));

    // Advance the frame on each oversample tick and capture the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            data     <= '0;
            par_bit  <= 1'b0;
            stop_bit <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx) begin
                            state  <= ST_START;
                            os_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (os_cnt == CW'(HALF - 1)) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            os_cnt <= os_cnt + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (at_bit_mid) begin
                            os_cnt <= '0;
                            data   <= {rx, data[DATA_BITS-1:1]};
                            if (bit_idx == IW'(DATA_BITS - 1))
                                state <= PAR_EN ? ST_PAR : ST_STOP;
                            else
                                bit_idx <= bit_idx + IW'(1);
                        end else begin
                            os_cnt <= os_cnt + CW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (at_bit_mid) begin
                            os_cnt  <= '0;
                            par_bit <= rx;
                            state   <= ST_STOP;
                        end else begin
                            os_cnt <= os_cnt + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (at_bit_mid) begin
                            os_cnt   <= '0;
                            stop_bit <= rx;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            os_cnt <= os_cnt + CW'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxe_judge.sv
// Judges a completed frame. It checks parity and the stop bit, looks
// at the queue's full flag, and drives the push and error pulses one
// cycle after done. A bad stop bit takes priority over overrun.
module rxe_judge #(
    parameter int                 DATA_BITS = 8,
    parameter rxe_pkg::par_mode_e PARITY    = rxe_pkg::PAR_EVEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 par_bit,
    input  logic                 stop_bit,
    input  logic                 fifo_full,
    output logic                 push_valid,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_overrun
);
    import rxe_pkg::*;

    logic par_bad;
    logic frame_bad;

    // Compare the received parity bit with the one the mode requires.
    always_comb begin
        case (PARITY)
            PAR_EVEN: par_bad = (^data) ^ par_bit;
            PAR_ODD:  par_bad = ~((^data) ^ par_bit);
            default:  par_bad = 1'b0;
        endcase
        frame_bad = ~stop_bit;
    end

    // Register the outcome of each completed frame as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid  <= 1'b0;
            push_data   <= '0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            push_valid  <= done & ~frame_bad & ~fifo_full;
            err_parity  <= done & par_bad;
            err_frame   <= done & frame_bad;
            err_overrun <= done & ~frame_bad & fifo_full;
            if (done) push_data <= data;
        end
    end
endmodule

// File: rtl/rxe_uart_rx.sv
// Top of the serial receiver: synchronizer, frame state machine and
// outcome judge. The caller supplies a 16x baud tick and a receive
// queue with a push/full handshake.
module rxe_uart_rx #(
    parameter int                 DATA_BITS = 8,
    parameter rxe_pkg::par_mode_e PARITY    = rxe_pkg::PAR_EVEN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rx_line,
    input  logic                 fifo_full,
    output logic                 push_valid,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_overrun
);
    localparam bit PAR_EN = (PARITY != rxe_pkg::PAR_NONE);

    logic                 rx_s;
    logic                 fr_done;
    logic [DATA_BITS-1:0] fr_data;
    logic                 fr_par;
    logic                 fr_stop;

    rxe_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line),
        .q     (rx_s)
    );

    rxe_framer #(.DATA_BITS(DATA_BITS), .PAR_EN(PAR_EN), .OSR(rxe_pkg::OSR)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .rx       (rx_s),
        .done     (fr_done),
        .data     (fr_data),
        .par_bit  (fr_par),
        .stop_bit (fr_stop)
    );

    rxe_judge #(.DATA_BITS(DATA_BITS), .PARITY(PARITY)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (fr_done),
        .data        (fr_data),
        .par_bit     (fr_par),
        .stop_bit    (fr_stop),
        .fifo_full   (fifo_full),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun)
    );
endmodule

// File: rtl/rxe_uart_rx_chk.sv
// Checker for the serial receiver's outcome pulses, bound to the top.
module rxe_uart_rx_chk #(
    parameter rxe_pkg::par_mode_e PARITY = rxe_pkg::PAR_EVEN
) (
    input logic clk,
    input logic rst_n,
    input logic fifo_full,
    input logic push_valid,
    input logic err_parity,
    input logic err_frame,
    input logic err_overrun
);
    // R1: outputs are quiet on the first cycle out of reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(push_valid | err_parity | err_frame | err_overrun));

    // R8: each strobe lasts a single cycle.
    p_push_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |=> !push_valid);
    p_frame_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> !err_frame);
    p_overrun_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> !err_overrun);

    // R5: a bad stop bit never stores.
    p_frame_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |-> !push_valid);

    // R6: no push when full; overrun only when full and never with a frame error.
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !$past(fifo_full));
    p_overrun_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> ($past(fifo_full) && !err_frame));

    // R3: a parity error alone still stores the character.
    p_parity_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_frame && !err_overrun) |-> push_valid);

    // R4: no parity errors when parity is disabled.
    if (PARITY == rxe_pkg::PAR_NONE) begin : g_no_parity
        p_parity_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !err_parity);
    end
endmodule

bind rxe_uart_rx rxe_uart_rx_chk #(.PARITY(PARITY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_full   (fifo_full),
    .push_valid  (push_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun)
);

// File: tb/rxe_uart_rx_tb_top.sv
// Bench: three receiver lanes (8-bit even, 5-bit odd, 6-bit none).
// Each frame's expected outcome goes into a per-lane queue, and the
// outputs are compared against it on every falling clock edge.
module rxe_uart_rx_tb_top;
    localparam int BIT_CLKS = 64;   // 16 ticks of 4 clocks

    typedef struct {
        logic [7:0] data;
        bit         push;
        bit         pe;
        bit         fe;
        bit         oe;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] rx = 3'b111;
    logic       full = 1'b0;

    logic       pv0, pe0, fe0, oe0;
    logic [7:0] d0;
    logic       pv1, pe1, fe1, oe1;
    logic [4:0] d1;
    logic       pv2, pe2, fe2, oe2;
    logic [5:0] d2;

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];
    int   checks = 0;
    int   errors = 0;
    int   tcnt = 0;

    always #5 clk = ~clk;

    rxe_uart_rx #(.DATA_BITS(8), .PARITY(rxe_pkg::PAR_EVEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_line(rx[0]), .fifo_full(full),
        .push_valid(pv0), .push_data(d0), .err_parity(pe0), .err_frame(fe0), .err_overrun(oe0));
    rxe_uart_rx #(.DATA_BITS(5), .PARITY(rxe_pkg::PAR_ODD)) dut_odd (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_line(rx[1]), .fifo_full(full),
        .push_valid(pv1), .push_data(d1), .err_parity(pe1), .err_frame(fe1), .err_overrun(oe1));
    rxe_uart_rx #(.DATA_BITS(6), .PARITY(rxe_pkg::PAR_NONE)) dut_none (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_line(rx[2]), .fifo_full(full),
        .push_valid(pv2), .push_data(d2), .err_parity(pe2), .err_frame(fe2), .err_overrun(oe2));

    // Tick generator: one cycle in four, driven away from the active edge.
    always @(negedge clk) begin
        tick <= (tcnt == 3);
        tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    end

    function automatic int lane_bits(input int lane);
        return (lane == 0) ? 8 : (lane == 1) ? 5 : 6;
    endfunction

    function automatic int lane_par(input int lane);
        return (lane == 0) ? 1 : (lane == 1) ? 2 : 0;
    endfunction

    task automatic mon(input int lane, input logic pv, input logic [7:0] d,
                       input logic pe, input logic fe, input logic oe);
        exp_t e;
        bit   have = 0;
        if (!(pv | pe | fe | oe)) return;
        case (lane)
            0: if (q0.size() > 0) begin e = q0.pop_front(); have = 1; end
            1: if (q1.size() > 0) begin e = q1.pop_front(); have = 1; end
            default: if (q2.size() > 0) begin e = q2.pop_front(); have = 1; end
        endcase
        checks++;
        if (!have) begin
            errors++;
            $display("FAIL lane %0d R8 unexpected outcome push=%b pe=%b fe=%b oe=%b expected none",
                     lane, pv, pe, fe, oe);
        end else if ({pv, pe, fe, oe} != {e.push, e.pe, e.fe, e.oe} || (pv && d != e.data)) begin
            errors++;
            $display("FAIL lane %0d %s push=%b pe=%b fe=%b oe=%b data=%h expected push=%b pe=%b fe=%b oe=%b data=%h",
                     lane, e.req, pv, pe, fe, oe, d, e.push, e.pe, e.fe, e.oe, e.data);
        end
    endtask

    // Compare every lane's outputs with its expectation queue.
    always @(negedge clk) begin
        if (rst_n) begin
            mon(0, pv0, d0, pe0, fe0, oe0);
            mon(1, pv1, {3'b000, d1}, pe1, fe1, oe1);
            mon(2, pv2, {2'b00, d2}, pe2, fe2, oe2);
        end
    end

    task automatic drain(input int lane, input string req);
        int n;
        n = (lane == 0) ? q0.size() : (lane == 1) ? q1.size() : q2.size();
        checks++;
        if (n != 0) begin
            errors++;
            $display("FAIL lane %0d %s missing outcomes: %0d pending, expected 0", lane, req, n);
        end
    endtask

    task automatic hold_bit(input int lane, input logic v);
        rx[lane] = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic frame(input int lane, input logic [7:0] data, input bit bad_par,
                         input bit stop_val, input bit idle, input string req);
        exp_t e;
        int   nb = lane_bits(lane);
        int   pm = lane_par(lane);
        logic [7:0] m = data & 8'((1 << nb) - 1);
        logic p = (pm == 2) ? ~(^m) : (^m);
        if (bad_par) p = ~p;
        e.data = m;
        e.fe   = !stop_val;
        e.pe   = (pm != 0) && bad_par;
        e.oe   = stop_val && full;
        e.push = stop_val && !full;
        e.req  = req;
        case (lane)
            0: q0.push_back(e);
            1: q1.push_back(e);
            default: q2.push_back(e);
        endcase
        hold_bit(lane, 1'b0);
        for (int i = 0; i < nb; i++) hold_bit(lane, m[i]);
        if (pm != 0) hold_bit(lane, p);
        hold_bit(lane, stop_val);
        rx[lane] = 1'b1;
        if (idle) begin
            repeat (BIT_CLKS) @(negedge clk);
            drain(lane, req);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired R8 stimulus incomplete, expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        // R1: quiet during reset
        checks++;
        if ({pv0, pe0, fe0, oe0, pv1, pe1, fe1, oe1, pv2, pe2, fe2, oe2} != 12'b0) begin
            errors++;
            $display("FAIL R1 outputs in reset %b expected 0",
                     {pv0, pe0, fe0, oe0, pv1, pe1, fe1, oe1, pv2, pe2, fe2, oe2});
        end
        rst_n = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        checks++;
        if ({pv0, pe0, fe0, oe0, pv1, pe1, fe1, oe1, pv2, pe2, fe2, oe2} != 12'b0) begin
            errors++;
            $display("FAIL R1 outputs after reset %b expected 0",
                     {pv0, pe0, fe0, oe0, pv1, pe1, fe1, oe1, pv2, pe2, fe2, oe2});
        end

        // Lane 0: 8 data bits, even parity
        frame(0, 8'hA5, 0, 1, 1, "R2 good A5");
        frame(0, 8'h00, 0, 1, 1, "R2 good 00");
        frame(0, 8'hFF, 0, 1, 1, "R2 good FF");
        frame(0, 8'h3C, 1, 1, 1, "R3 parity error stored");
        frame(0, 8'h5A, 0, 0, 1, "R5 framing error dropped");
        frame(0, 8'h96, 1, 0, 1, "R5 framing and parity");
        full = 1'b1;
        frame(0, 8'h71, 0, 1, 1, "R6 overrun dropped");
        frame(0, 8'h72, 0, 0, 1, "R6 full with bad stop gives frame only");
        frame(0, 8'h73, 1, 1, 1, "R6 full with parity error");
        full = 1'b0;
        // R7: short low glitch is ignored
        rx[0] = 1'b0;
        repeat (8) @(negedge clk);
        rx[0] = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        drain(0, "R7 glitch");
        // R8: back-to-back frames
        frame(0, 8'h81, 0, 1, 0, "R8 first of pair");
        frame(0, 8'h7E, 0, 1, 1, "R8 second of pair");

        // Lane 1: 5 data bits, odd parity
        frame(1, 8'h15, 0, 1, 1, "R2 odd 5-bit good");
        frame(1, 8'h0A, 1, 1, 1, "R3 odd parity error stored");
        frame(1, 8'h1F, 0, 1, 1, "R3 odd all ones");
        full = 1'b1;
        frame(1, 8'h03, 0, 1, 1, "R6 odd overrun");
        full = 1'b0;

        // Lane 2: 6 data bits, no parity
        frame(2, 8'h2D, 0, 1, 1, "R4 no parity good");
        frame(2, 8'h3F, 1, 1, 1, "R4 no parity bit expected");
        frame(2, 8'h12, 0, 0, 1, "R5 no parity framing error");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule